// File: doc/BRIEF.md
# Multichannel DAC Special-Command Controller

This block sits behind the parallel command port of a 32-channel, 12-bit converter. It decodes each incoming word and keeps the digital state of the converter. A word carries a read/write flag, a two-bit register select, a five-bit address and twelve data bits. When the register select is non-zero, the word is a channel access: it reads or writes the gain, offset or data register of the channel that the address picks. When the register select is zero, the address is a command code. The commands are no-op, write clear code, soft clear, power-down, power-up, monitor request, control-register write or read, and soft reset.

Each accepted command drives `busy_n` low for its own number of clock cycles, and these counts are set by parameters. A word that arrives while `busy_n` is low is discarded and flagged. The power-down state is the OR of a software state and the `pwr_dn_in` pin. While it is active, every register keeps its value and ignores all writes. The clear-code value is loaded into every channel's data register by either a soft clear or `clr_in_n` held low. Read results are held in a readback latch, and a later no-op presents that latch on `rd_data`.

The sequencer has three states. `ST_IDLE` has `busy_n` high. On a valid word, the `accept` transition moves to `ST_EXEC` and loads the countdown. `ST_EXEC` lasts one cycle, and the command takes effect at its closing edge. If the countdown is zero, the `done` transition returns to `ST_IDLE`. Otherwise the `extend` transition moves to `ST_HOLD`. `ST_HOLD` counts down and leaves through `done` when the count reaches zero.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: A word is a command only when `cmd_sel` = 00. The address then selects the command: 00000 no-op, 00001 write clear code, 00010 soft clear, 01000 power-down, 01001 power-up, 01010 monitor request, 01100 control access, 01111 soft reset. All other addresses have no effect on any register or output apart from `busy_n`.
- R2: `busy_n` goes low in the cycle after the word is accepted and stays low for exactly D cycles. D is T_CLR for soft clear, T_PU for power-up, T_RST for soft reset, and T_SHORT for every other word, including channel accesses and unknown codes.
- R3: A word presented while `busy_n` is low is discarded, and `cmd_drop` is high for the one cycle after it.
- R4: Write clear code stores `cmd_data` as the clear code. The clear code is 0 after reset.
- R5: A soft clear, or `clr_in_n` low at a clock edge, loads the clear code into the data register of every channel.
- R6: `powered_down` is the OR of the soft power-down state and `pwr_dn_in`. While it is high, the following are all ignored and every value is kept: channel writes, clear-code writes, control writes, soft clear and external clear. Power-up clears the soft state. Reads still work while powered down.
- R7: Soft reset sets every gain register to FFF, and every offset register, data register, the control register and the clear code to 0. Soft reset is ignored while powered down.
- R8: Control access (address 01100) writes `cmd_data` into the control register when `cmd_rw` = 0. When `cmd_rw` = 1, it copies the control register into the readback latch.
- R9: A no-op puts the readback latch on `rd_data`, with `rd_valid` high for the one cycle starting two clock edges after acceptance. Repeated no-ops return the same word.
- R10: For `cmd_sel` 01 = gain, 10 = offset and 11 = data, with the address as the channel: `cmd_rw` = 0 writes the register and repeats the word on the `chw_*` port two edges after acceptance. `cmd_rw` = 1 copies the register into the readback latch.
- R11: The monitor request pulses `mon_req` for one cycle, two edges after acceptance, with `mon_chan` = `cmd_data[4:0]`.
- R12: After reset, `busy_n` = 1, `rd_data` = 0 and `powered_down` = `pwr_dn_in`. Every gain register reads FFF, and every offset and data register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Word present this cycle |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_sel | input | 2 | Register select (00 = command) |
| cmd_addr | input | 5 | Channel or command code |
| cmd_data | input | 12 | Data field |
| clr_in_n | input | 1 | External clear, active low |
| pwr_dn_in | input | 1 | Hardware power-down request |
| busy_n | output | 1 | Low while a command executes |
| cmd_drop | output | 1 | Pulse: word discarded while busy |
| powered_down | output | 1 | Effective power-down state |
| rd_valid | output | 1 | Pulse: `rd_data` updated by a no-op |
| rd_data | output | 12 | Readback word |
| chw_valid | output | 1 | Pulse: channel write applied |
| chw_sel | output | 2 | Register select of the applied write |
| chw_addr | output | 5 | Channel of the applied write |
| chw_data | output | 12 | Data of the applied write |
| mon_req | output | 1 | Pulse: monitor request decoded |
| mon_chan | output | 5 | Channel requested for monitoring |

## Verification
The hardest situation to reach is the power-down lockout, because it is only visible when a locked-out write is followed by a read that shows nothing changed. The stimulus enters soft power-down and then issues every kind of write: a channel write, a clear-code write, a soft clear, an external clear pulse, a control write and a soft reset. It then reads registers while still powered down. After power-up, a soft clear shows that the old clear code survived. A separate phase repeats a channel write under the hardware power-down pin. Dropped words are produced by presenting a control write in the cycle after a long soft clear has been accepted, and then reading the control register back.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_WCLR,
        OP_SCLR,
        OP_PD,
        OP_PU,
        OP_MON,
        OP_CTL_WR,
        OP_CTL_RD,
        OP_SRST,
        OP_CH_WR,
        OP_CH_RD,
        OP_IGN
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_HOLD
    } st_e;

    localparam logic [4:0] CODE_NOP  = 5'b00000;
    localparam logic [4:0] CODE_WCLR = 5'b00001;
    localparam logic [4:0] CODE_SCLR = 5'b00010;
    localparam logic [4:0] CODE_PD   = 5'b01000;
    localparam logic [4:0] CODE_PU   = 5'b01001;
    localparam logic [4:0] CODE_MON  = 5'b01010;
    localparam logic [4:0] CODE_CTL  = 5'b01100;
    localparam logic [4:0] CODE_SRST = 5'b01111;

    localparam logic [1:0] SEL_CMD  = 2'b00;
    localparam logic [1:0] SEL_GAIN = 2'b01;
    localparam logic [1:0] SEL_OFFS = 2'b10;
    localparam logic [1:0] SEL_DATA = 2'b11;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          rw,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] addr,
    output op_e           op
);

    always_comb begin
        op = OP_IGN;
        if (sel != SEL_CMD) begin
            op = rw ? OP_CH_RD : OP_CH_WR;
        end else begin
            case (addr)
                CODE_NOP:  op = OP_NOP;
                CODE_WCLR: op = OP_WCLR;
                CODE_SCLR: op = OP_SCLR;
                CODE_PD:   op = OP_PD;
                CODE_PU:   op = OP_PU;
                CODE_MON:  op = OP_MON;
                CODE_CTL:  op = rw ? OP_CTL_RD : OP_CTL_WR;
                CODE_SRST: op = OP_SRST;
                default:   op = OP_IGN;
            endcase
        end
    end

endmodule

// File: rtl/dac_cmd_fsm.sv
module dac_cmd_fsm
    import dac_cmd_pkg::*;
#(
    parameter int T_SHORT = 2,
    parameter int T_CLR   = 35,
    parameter int T_PU    = 8,
    parameter int T_RST   = 135
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  op_e  op_in,
    output logic idle,
    output logic accept,
    output logic exec
);

    localparam int T_M1  = (T_SHORT > T_CLR) ? T_SHORT : T_CLR;
    localparam int T_M2  = (T_PU > T_RST) ? T_PU : T_RST;
    localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CW    = $clog2(T_MAX + 1);

    st_e           st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] dur;

    always_comb begin
        unique case (op_in)
            OP_SCLR: dur = CW'(T_CLR);
            OP_PU:   dur = CW'(T_PU);
            OP_SRST: dur = CW'(T_RST);
            default: dur = CW'(T_SHORT);
        endcase
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    st_d  = ST_EXEC;
                    cnt_d = dur - CW'(1);
                end
            end
            ST_EXEC, ST_HOLD: begin
                if (cnt_q == '0) begin
                    st_d = ST_IDLE;
                end else begin
                    st_d  = ST_HOLD;
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        idle   = (st_q == ST_IDLE);
        exec   = (st_q == ST_EXEC);
        accept = idle && cmd_valid;
    end

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
    import dac_cmd_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 12,
    parameter int AW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_all,
    input  logic [DW-1:0] clr_code,
    input  logic          rst_all,
    input  logic [1:0]    rd_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);

    logic [NCH-1:0][DW-1:0] gain_w;
    logic [NCH-1:0][DW-1:0] offs_w;
    logic [NCH-1:0][DW-1:0] data_w;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic          hit;
        logic [DW-1:0] gain_q, offs_q, data_q;

        assign hit = wr_en && (wr_addr == AW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n || rst_all) begin
                gain_q <= {DW{1'b1}};
                offs_q <= '0;
                data_q <= '0;
            end else begin
                if (hit && wr_sel == SEL_GAIN) gain_q <= wr_data;
                if (hit && wr_sel == SEL_OFFS) offs_q <= wr_data;
                if (clr_all)                        data_q <= clr_code;
                else if (hit && wr_sel == SEL_DATA) data_q <= wr_data;
            end
        end

        assign gain_w[g] = gain_q;
        assign offs_w[g] = offs_q;
        assign data_w[g] = data_q;
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_addr) < NCH) begin
            unique case (rd_sel)
                SEL_GAIN: rd_word = gain_w[rd_addr];
                SEL_OFFS: rd_word = offs_w[rd_addr];
                SEL_DATA: rd_word = data_w[rd_addr];
                default:  rd_word = '0;
            endcase
        end
    end

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_cmd_pkg::*;
#(
    parameter int NCH     = 32,
    parameter int DW      = 12,
    parameter int T_SHORT = 2,
    parameter int T_CLR   = 35,
    parameter int T_PU    = 8,
    parameter int T_RST   = 135
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_rw,
    input  logic [1:0]    cmd_sel,
    input  logic [4:0]    cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          clr_in_n,
    input  logic          pwr_dn_in,
    output logic          busy_n,
    output logic          cmd_drop,
    output logic          powered_down,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          chw_valid,
    output logic [1:0]    chw_sel,
    output logic [4:0]    chw_addr,
    output logic [DW-1:0] chw_data,
    output logic          mon_req,
    output logic [4:0]    mon_chan
);

    localparam int AW    = 5;
    localparam int T_M1  = (T_SHORT > T_CLR) ? T_SHORT : T_CLR;
    localparam int T_M2  = (T_PU > T_RST) ? T_PU : T_RST;
    localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;

    op_e           op_in, cur_op;
    logic          cur_rw;
    logic [1:0]    cur_sel;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic          idle, accept, exec;
    logic          pd_soft, lock;
    logic [DW-1:0] clr_code, ctrl_q, rb_q, rd_word;
    logic          rf_wr, rf_clr, rf_rst;

    dac_cmd_decode #(.AW(AW)) u_dec (
        .rw   (cmd_rw),
        .sel  (cmd_sel),
        .addr (cmd_addr),
        .op   (op_in)
    );

    dac_cmd_fsm #(
        .T_SHORT (T_SHORT),
        .T_CLR   (T_CLR),
        .T_PU    (T_PU),
        .T_RST   (T_RST)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op_in     (op_in),
        .idle      (idle),
        .accept    (accept),
        .exec      (exec)
    );

    assign lock   = pd_soft || pwr_dn_in;
    assign rf_wr  = exec && !lock && (cur_op == OP_CH_WR);
    assign rf_rst = exec && !lock && (cur_op == OP_SRST);
    assign rf_clr = !lock && ((exec && cur_op == OP_SCLR) || !clr_in_n);

    dac_chan_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_wr),
        .wr_sel   (cur_sel),
        .wr_addr  (cur_addr),
        .wr_data  (cur_data),
        .clr_all  (rf_clr),
        .clr_code (clr_code),
        .rst_all  (rf_rst),
        .rd_sel   (cur_sel),
        .rd_addr  (cur_addr),
        .rd_word  (rd_word)
    );

    // command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op   <= OP_NOP;
            cur_rw   <= 1'b0;
            cur_sel  <= '0;
            cur_addr <= '0;
            cur_data <= '0;
        end else if (accept) begin
            cur_op   <= op_in;
            cur_rw   <= cmd_rw;
            cur_sel  <= cmd_sel;
            cur_addr <= cmd_addr;
            cur_data <= cmd_data;
        end
    end

    // special-function state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_soft  <= 1'b0;
            clr_code <= '0;
            ctrl_q   <= '0;
            rb_q     <= '0;
        end else if (exec) begin
            unique case (cur_op)
                OP_PD:     pd_soft <= 1'b1;
                OP_PU:     pd_soft <= 1'b0;
                OP_WCLR:   if (!lock) clr_code <= cur_data;
                OP_CTL_WR: if (!lock) ctrl_q <= cur_data;
                OP_SRST: begin
                    if (!lock) begin
                        clr_code <= '0;
                        ctrl_q   <= '0;
                    end
                end
                OP_CTL_RD: rb_q <= ctrl_q;
                OP_CH_RD:  rb_q <= rd_word;
                default:   ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_drop  <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            chw_valid <= 1'b0;
            chw_sel   <= '0;
            chw_addr  <= '0;
            chw_data  <= '0;
            mon_req   <= 1'b0;
            mon_chan  <= '0;
        end else begin
            cmd_drop  <= cmd_valid && !idle;
            rd_valid  <= exec && (cur_op == OP_NOP);
            chw_valid <= rf_wr && !cur_rw;
            mon_req   <= exec && (cur_op == OP_MON);
            if (exec && cur_op == OP_NOP) rd_data <= rb_q;
            if (rf_wr) begin
                chw_sel  <= cur_sel;
                chw_addr <= cur_addr;
                chw_data <= cur_data;
            end
            if (exec && cur_op == OP_MON) mon_chan <= cur_data[4:0];
        end
    end

    assign busy_n       = idle;
    assign powered_down = lock;

endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk #(
    parameter int T_MAX = 135
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy_n,
    input logic cmd_drop,
    input logic powered_down,
    input logic rd_valid,
    input logic chw_valid,
    input logic mon_req
);

    localparam int CW = $clog2(T_MAX + 2);
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || busy_n) low_cnt <= '0;
        else                  low_cnt <= low_cnt + CW'(1);
    end

    a_r2_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy_n |=> !busy_n);

    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> (int'(low_cnt) < T_MAX));

    a_r3_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy_n |=> cmd_drop);

    a_r6_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down |=> !chw_valid);

    a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r11_mon_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mon_req |-> $past(!busy_n));

endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.T_MAX(T_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy_n       (busy_n),
    .cmd_drop     (cmd_drop),
    .powered_down (powered_down),
    .rd_valid     (rd_valid),
    .chw_valid    (chw_valid),
    .mon_req      (mon_req)
);

// File: tb/dac_cmd_ctrl_tb.sv
module dac_cmd_ctrl_tb;

    localparam int TS = 2, TC = 35, TP = 8, TR = 135;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_rw = 1'b0;
    logic [1:0]  cmd_sel = '0;
    logic [4:0]  cmd_addr = '0;
    logic [11:0] cmd_data = '0;
    logic        clr_in_n = 1'b1, pwr_dn_in = 1'b0;
    logic        busy_n, cmd_drop, powered_down, rd_valid, chw_valid, mon_req;
    logic [11:0] rd_data, chw_data;
    logic [1:0]  chw_sel;
    logic [4:0]  chw_addr, mon_chan;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [11:0] exp_rd[$];
    string       exp_rd_tag[$];
    int          exp_dur[$];

    always #10 clk = ~clk;

    dac_cmd_ctrl #(.T_SHORT(TS), .T_CLR(TC), .T_PU(TP), .T_RST(TR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rw(cmd_rw),
        .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .clr_in_n(clr_in_n), .pwr_dn_in(pwr_dn_in), .busy_n(busy_n),
        .cmd_drop(cmd_drop), .powered_down(powered_down), .rd_valid(rd_valid),
        .rd_data(rd_data), .chw_valid(chw_valid), .chw_sel(chw_sel),
        .chw_addr(chw_addr), .chw_data(chw_data), .mon_req(mon_req),
        .mon_chan(mon_chan)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int dur_of(input logic [1:0] sel, input logic [4:0] addr);
        if (sel != 2'b00)      return TS;
        if (addr == 5'b00010)  return TC;
        if (addr == 5'b01001)  return TP;
        if (addr == 5'b01111)  return TR;
        return TS;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (!busy_n) @(negedge clk);
    endtask

    // driver: pushes expected busy length, presents one word
    task automatic send(input logic rw, input logic [1:0] sel, input logic [4:0] addr,
                        input logic [11:0] data);
        wait_idle();
        exp_dur.push_back(dur_of(sel, addr));
        cmd_valid = 1'b1; cmd_rw = rw; cmd_sel = sel; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic rw, input logic [1:0] sel, input logic [4:0] addr,
                          input logic [11:0] exp, input string tag);
        send(rw, sel, addr, 12'h000);
        exp_rd.push_back(exp);
        exp_rd_tag.push_back(tag);
        send(1'b0, 2'b00, 5'b00000, 12'h000);
    endtask

    task automatic pulse_clr();
        wait_idle();
        clr_in_n = 1'b0;
        @(negedge clk);
        clr_in_n = 1'b1;
    endtask

    // monitor: readback words
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) chk("R9 unexpected rd_valid", 1, 0);
            else chk(exp_rd_tag.pop_front(), rd_data, exp_rd.pop_front());
        end
    end

    // monitor: busy length per command
    int low_cycles = 0;
    always @(negedge clk) begin
        if (rst_n && !busy_n) low_cycles++;
        else if (low_cycles > 0) begin
            if (exp_dur.size() == 0) chk("R2 unexpected busy", 1, 0);
            else chk("R2 busy length", low_cycles, exp_dur.pop_front());
            low_cycles = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 busy_n reset", busy_n, 1);
        chk("R12 rd_data reset", rd_data, 0);
        chk("R12 powered_down reset", powered_down, 0);
        rd_chk(1, 2'b01, 5'd5, 12'hFFF, "R12 gain default");
        rd_chk(1, 2'b10, 5'd5, 12'h000, "R12 offset default");
        rd_chk(1, 2'b11, 5'd5, 12'h000, "R12 data default");

        // R4 R5 soft clear
        send(0, 2'b00, 5'b00001, 12'hA5C);
        send(0, 2'b00, 5'b00010, 12'h000);
        rd_chk(1, 2'b11, 5'd0, 12'hA5C, "R5 soft clear ch0");
        rd_chk(1, 2'b11, 5'd31, 12'hA5C, "R5 soft clear ch31");

        // R10 channel writes
        send(0, 2'b11, 5'd3, 12'h123);
        @(negedge clk);
        chk("R10 chw_valid", chw_valid, 1);
        chk("R10 chw word", {chw_sel, chw_addr, chw_data}, {2'b11, 5'd3, 12'h123});
        send(0, 2'b10, 5'd3, 12'h456);
        send(0, 2'b01, 5'd31, 12'h789);
        rd_chk(1, 2'b11, 5'd3, 12'h123, "R10 data ch3");
        rd_chk(1, 2'b10, 5'd3, 12'h456, "R10 offset ch3");
        rd_chk(1, 2'b01, 5'd31, 12'h789, "R10 gain ch31");

        // R5 external clear
        send(0, 2'b00, 5'b00001, 12'h3F0);
        pulse_clr();
        rd_chk(1, 2'b11, 5'd3, 12'h3F0, "R5 ext clear ch3");
        rd_chk(1, 2'b10, 5'd3, 12'h456, "R5 offset untouched");

        // R8 R9 control
        send(0, 2'b00, 5'b01100, 12'h2B1);
        rd_chk(1, 2'b00, 5'b01100, 12'h2B1, "R8 ctrl read");
        exp_rd.push_back(12'h2B1); exp_rd_tag.push_back("R9 repeat nop");
        send(0, 2'b00, 5'b00000, 12'h000);

        // R11 monitor and R1 unknown code
        send(0, 2'b00, 5'b01010, 12'h01D);
        @(negedge clk);
        chk("R11 mon_req", mon_req, 1);
        chk("R11 mon_chan", mon_chan, 5'h1D);
        send(0, 2'b00, 5'b00111, 12'hFFF);
        @(negedge clk);
        chk("R1 unknown no pulse", {chw_valid, mon_req, rd_valid}, 3'b000);
        rd_chk(1, 2'b11, 5'd3, 12'h3F0, "R1 unknown no effect");

        // R6 R7 soft power-down lockout
        send(0, 2'b00, 5'b01000, 12'h000);
        @(negedge clk);
        chk("R6 soft pd", powered_down, 1);
        send(0, 2'b11, 5'd3, 12'h777);
        @(negedge clk);
        chk("R6 chw blocked", chw_valid, 0);
        send(0, 2'b00, 5'b00001, 12'h111);
        send(0, 2'b00, 5'b00010, 12'h000);
        pulse_clr();
        send(0, 2'b00, 5'b01100, 12'h0AA);
        send(0, 2'b00, 5'b01111, 12'h000);
        rd_chk(1, 2'b11, 5'd3, 12'h3F0, "R6 data kept");
        rd_chk(1, 2'b00, 5'b01100, 12'h2B1, "R6 ctrl kept");
        rd_chk(1, 2'b01, 5'd31, 12'h789, "R7 reset ignored in pd");
        send(0, 2'b00, 5'b01001, 12'h000);
        @(negedge clk);
        chk("R6 power-up", powered_down, 0);
        send(0, 2'b11, 5'd3, 12'h555);
        send(0, 2'b00, 5'b00010, 12'h000);
        rd_chk(1, 2'b11, 5'd3, 12'h3F0, "R6 clear code kept");

        // R6 hardware power-down
        wait_idle();
        pwr_dn_in = 1'b1;
        @(negedge clk);
        chk("R6 hw pd", powered_down, 1);
        send(0, 2'b11, 5'd4, 12'h0F0);
        wait_idle();
        pwr_dn_in = 1'b0;
        rd_chk(1, 2'b11, 5'd4, 12'h3F0, "R6 hw pd blocks write");

        // R3 drop while busy
        send(0, 2'b00, 5'b00010, 12'h000);
        cmd_valid = 1'b1; cmd_rw = 1'b0; cmd_sel = 2'b00; cmd_addr = 5'b01100; cmd_data = 12'hBAD;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 cmd_drop", cmd_drop, 1);
        @(negedge clk);
        chk("R3 drop one cycle", cmd_drop, 0);
        rd_chk(1, 2'b00, 5'b01100, 12'h2B1, "R3 dropped write");

        // R7 soft reset
        send(0, 2'b00, 5'b01111, 12'h000);
        rd_chk(1, 2'b01, 5'd31, 12'hFFF, "R7 gain full");
        rd_chk(1, 2'b10, 5'd3, 12'h000, "R7 offset zero");
        rd_chk(1, 2'b11, 5'd3, 12'h000, "R7 data zero");
        rd_chk(1, 2'b00, 5'b01100, 12'h000, "R7 ctrl zero");
        send(0, 2'b11, 5'd0, 12'h321);
        send(0, 2'b00, 5'b00010, 12'h000);
        rd_chk(1, 2'b11, 5'd0, 12'h000, "R7 clear code zero");

        wait_idle();
        repeat (4) @(negedge clk);
        chk("R9 scoreboard drained", exp_rd.size(), 0);
        chk("R2 scoreboard drained", exp_dur.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule